// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns a single starting address into the address sequence of a four-beat burst. A caller either loads a fresh external address or asks the block to step to the next beat. Each step moves an internal two-bit beat counter. The two lowest address bits are then recomputed from the loaded start offset and the beat count, in one of two orderings. All higher address bits stay at their loaded value.

The two orderings are a linear one and an interleaved one. Linear order adds the beat to the start offset and wraps inside the four-word group. Interleaved order XORs the beat with the start offset. A static select input picks the ordering. An active-low clock enable freezes the counter and the loaded address for as long as it is held high. The current address and the beat index come out combinationally from the held state, so the cycle after a load already presents the loaded address.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, the beat index and the stored address become zero, so `burstAddr` reads 0 and `beatIdx` reads 0 after that edge.
- R2: At an edge with `clkEnN` low and `advance` low, the block captures `extAddr`. After that edge, `burstAddr` equals the captured address and `beatIdx` is 0, whichever order is selected.
- R3: At an edge with `clkEnN` low and `advance` high, `beatIdx` increases by one modulo 4. After beat 3 it returns to beat 0 of the same burst.
- R4: With `orderXor` = 0 (linear), `burstAddr[1:0]` equals (start offset + `beatIdx`) modulo 4. For example, start 2 gives 2,3,0,1 and start 3 gives 3,0,1,2.
- R5: With `orderXor` = 1 (interleaved), `burstAddr[1:0]` equals start offset XOR `beatIdx`. For example, start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R6: `burstAddr[ADDR_W-1:2]` keeps its loaded value across every step, so a burst never leaves its four-word group.
- R7: At an edge with `clkEnN` high, `beatIdx` and the stored address keep their values. `advance` and `extAddr` have no effect at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clkEnN | input | 1 | Clock enable, active low; high freezes all state |
| advance | input | 1 | 0 = load `extAddr`, 1 = step to next beat |
| orderXor | input | 1 | Burst order: 0 = linear wrap, 1 = interleaved XOR |
| extAddr | input | ADDR_W (19) | External starting address |
| burstAddr | output | ADDR_W (19) | Address of the current beat |
| beatIdx | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
Every start offset from 0 to 3 is loaded under both orderings and then stepped past the fourth beat. Only the wrap and XOR sequences diverge for offsets 1 and 3, and only a run past beat 3 shows whether the counter wraps inside its group or carries into the upper bits. Freeze cycles are applied with `advance` high and with a different `extAddr` on the bus, which separates a correct hold from a stray step or a stray load. A long random mix of loads, steps, freezes and resets is compared beat by beat against a behavioural model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic          rst,
  input  logic          clkEnN,
  input  logic          advance,
  output burstStrobes_t strobes
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = !rst && !clkEnN && !advance;
    strobes.step  = !rst && !clkEnN && advance;
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  burstStrobes_t     strobes,
  input  logic              orderXor,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [$clog2(BURST_LEN)-1:0] beatIdx
);
  localparam int OFS_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] baseQ;
  logic [OFS_W-1:0]  beatQ;
  logic [OFS_W-1:0]  linOfs;
  logic [OFS_W-1:0]  xorOfs;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (strobes.load) begin
      baseQ <= extAddr;
      beatQ <= '0;
    end else if (strobes.step) begin
      beatQ <= beatQ + OFS_W'(1);
    end
  end

  always_comb begin
    linOfs = baseQ[OFS_W-1:0] + beatQ;
    xorOfs = baseQ[OFS_W-1:0] ^ beatQ;
  end

  generate
    if (ADDR_W > OFS_W) begin : g_upper
      assign burstAddr = {baseQ[ADDR_W-1:OFS_W], orderXor ? xorOfs : linOfs};
    end else begin : g_only_offset
      assign burstAddr = orderXor ? xorOfs : linOfs;
    end
  endgenerate

  assign beatIdx = beatQ;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              advance,
  input  logic              orderXor,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [$clog2(BURST_LEN)-1:0] beatIdx
);
  burstStrobes_t strobes;

  burst_ctrl u_ctrl (
    .rst     (rst),
    .clkEnN  (clkEnN),
    .advance (advance),
    .strobes (strobes)
  );

  burst_dp #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .orderXor  (orderXor),
    .extAddr   (extAddr),
    .burstAddr (burstAddr),
    .beatIdx   (beatIdx)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEnN,
  input logic              advance,
  input logic              orderXor,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] burstAddr,
  input logic [$clog2(BURST_LEN)-1:0] beatIdx
);
  localparam int OFS_W = $clog2(BURST_LEN);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (beatIdx == '0 && burstAddr == '0));

  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !advance) |=> (burstAddr == $past(extAddr) && beatIdx == '0));

  assert_step_count_R3: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance) |=> (beatIdx == $past(beatIdx) + OFS_W'(1)));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance && !orderXor) |=>
      (orderXor || burstAddr[OFS_W-1:0] == $past(burstAddr[OFS_W-1:0]) + OFS_W'(1)));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance) |=>
      (burstAddr[ADDR_W-1:OFS_W] == $past(burstAddr[ADDR_W-1:OFS_W])));

  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(beatIdx) && (!$stable(orderXor) || $stable(burstAddr))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clkEnN    (clkEnN),
  .advance   (advance),
  .orderXor  (orderXor),
  .extAddr   (extAddr),
  .burstAddr (burstAddr),
  .beatIdx   (beatIdx)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int ADDR_W = 19;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clkEnN = 1'b0;
  logic              advance = 1'b0;
  logic              orderXor = 1'b0;
  logic [ADDR_W-1:0] extAddr = '0;
  logic [ADDR_W-1:0] burstAddr;
  logic [1:0]        beatIdx;

  int checks = 0;
  int errors = 0;
  int refBase = 0;
  int refBeat = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4)) u_dut (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .advance(advance),
    .orderXor(orderXor), .extAddr(extAddr),
    .burstAddr(burstAddr), .beatIdx(beatIdx)
  );

  // Drive at the falling edge, update the model at the rising edge,
  // then return at the next falling edge for sampling.
  task automatic cyc(input bit r, input bit enN, input bit adv, input bit ord,
                     input int addr);
    rst = r; clkEnN = enN; advance = adv; orderXor = ord;
    extAddr = ADDR_W'(addr);
    @(posedge clk);
    if (r) begin
      refBase = 0; refBeat = 0;
    end else if (!enN) begin
      if (!adv) begin
        refBase = addr & ((1 << ADDR_W) - 1); refBeat = 0;
      end else begin
        refBeat = (refBeat + 1) % 4;
      end
    end
    @(negedge clk);
  endtask

  task automatic checkNow(input string tag);
    int low;
    int expAddr;
    low = orderXor ? ((refBase & 3) ^ refBeat) : (((refBase & 3) + refBeat) % 4);
    expAddr = (refBase & ~3) | low;
    checks++;
    if (burstAddr !== ADDR_W'(expAddr) || beatIdx !== 2'(refBeat)) begin
      errors++;
      $display("FAIL %s burstAddr=%h expected=%h beatIdx=%0d expected=%0d",
               tag, burstAddr, ADDR_W'(expAddr), beatIdx, refBeat);
    end
  endtask

  task automatic burst(input bit ord, input int start, input string tag);
    cyc(0, 0, 0, ord, start);
    checkNow("R2");
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1, ord, 0);
      checkNow(tag);
    end
  endtask

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 5);
    checkNow("R1");

    // Linear wrap, every start offset (R4, R3 wrap after beat 3)
    for (int s = 0; s < 4; s++) burst(0, 'h2A5C0 + s, "R4");
    // Interleaved, every start offset (R5)
    for (int s = 0; s < 4; s++) burst(1, 'h13570 + s, "R5");

    // R6: start offset 3 near a group edge keeps the upper bits
    cyc(0, 0, 0, 0, 'h7FFFF);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 0, 0);
      checkNow("R6");
      checks++;
      if (burstAddr[ADDR_W-1:2] !== 17'h1FFFF) begin
        errors++;
        $display("FAIL R6 upper=%h expected=%h", burstAddr[ADDR_W-1:2], 17'h1FFFF);
      end
    end

    // R3: four steps return to beat 0
    cyc(0, 0, 0, 1, 'h00402);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0);
    checkNow("R3");

    // R7: freeze with advance high, then with a load request and new address
    cyc(0, 0, 0, 0, 'h31231);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 1, 1, 0, 'h0FFFF);
    checkNow("R7");
    cyc(0, 1, 0, 0, 'h44444);
    checkNow("R7");
    cyc(0, 0, 1, 0, 0);
    checkNow("R7");

    // R1 mid-burst reset
    cyc(1, 0, 1, 1, 'h55555);
    checkNow("R1");

    // Random mix; order changes only on loads
    begin
      bit ord = 0;
      for (int i = 0; i < 3000; i++) begin
        int sel = $urandom_range(0, 19);
        bit r   = (sel == 0);
        bit enN = (sel < 5) && !r;
        bit adv = (sel >= 8);
        if (!r && !enN && !adv) ord = $urandom_range(0, 1);
        cyc(r, enN, adv, ord, $urandom_range(0, (1 << ADDR_W) - 1));
        checkNow(r ? "R1" : enN ? "R7" : !adv ? "R2" : ord ? "R5" : "R4");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule